// File: doc/BRIEF.md
# System-Management RAM Access Gate

This block sits between the processor-side address decode and the memory paths of a host bridge. It decides where an access to the system-management memory areas lands. Two byte-wide control registers hold the gating policy. The first covers the open, lock and global-enable bits. The second covers the high-alias enable and the top-of-memory segment (TSEG) setup. A third 16-bit register lets software discover the extended segment size. The block also takes the top of low DRAM, the access address and a flag saying that the access comes from system-management mode. From these it reports a route:

- DRAM: the access reaches memory, with a translated DRAM address.
- Pass: the access goes to the legacy bus/video path, or to whatever else decodes that address.
- Blackhole: reads return all ones and writes are dropped.

The classification is combinational from the registered controls and the access inputs. A register write therefore changes routing from the next clock edge onward. A lock bit closes the open window and freezes most of the policy until reset.

Top module: `smram_gate`

## Requirements
- R1: On reset the first control register reads 0x02, the second reads 0x38, and the size-query register reads 0xFFFF (the configured extended size is non-zero).
- R2: Only these bits are writable when unlocked: bits 6 (open), 5 (close), 4 (lock) and 3 (global enable) of the first register, and bits 7 (high enable), 2:1 (segment size code) and 0 (segment enable) of the second register. All other bits keep their value. Select code 0 writes the first register, 1 the second, and 2 the query register.
- R3: A write that leaves the lock bit set clears the open bit in that same write. While locked, only bit 5 of the first register can change, the second register cannot change at all, and the lock is cleared only by reset.
- R4: When the segment is enabled, size code 0 gives 1 MB, code 1 gives 2 MB, code 2 gives 8 MB, and code 3 gives the configured extended size in MB (default 16). When the segment is disabled the size is 0.
- R5: The segment base equals top-of-low-memory minus the segment size. The base is 0 if the size exceeds the top.
- R6: Inside [base, top) with a non-zero size, a non-SMM access routes Blackhole (code 2) and an SMM access routes DRAM (code 0). This takes priority over every other region.
- R7: In the low window 0xA0000–0xBFFFF, a non-SMM access routes DRAM only when open is set and high enable is clear. Otherwise it routes Pass (code 1).
- R8: In the low window, an SMM access also routes DRAM when global enable is set and high enable is clear.
- R9: In the high window 0xFEDA0000–0xFEDBFFFF, an access routes DRAM with address translated to 0xA0000 plus the offset when high enable is set and either open is set or (the access is SMM and global enable is set). Otherwise it routes Pass.
- R10: Any other address routes DRAM below top-of-low-memory and Pass at or above it. The DRAM address equals the access address.
- R11: Writing 0xFFFF to the query register makes it read back the configured extended size in MB. Any other value is stored as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select: 0 first control, 1 second control, 2 size query |
| cfg_wdata | input | 16 | Write data (low byte for the control registers) |
| smram_q | output | 8 | First control register contents |
| esm_q | output | 8 | Second control register contents |
| ext_q | output | 16 | Size-query register contents |
| low_top | input | 32 | Top of low DRAM in bytes |
| acc_addr | input | 32 | Access address |
| acc_smm | input | 1 | Access issued in system-management mode |
| acc_route | output | 2 | 0 DRAM, 1 Pass, 2 Blackhole |
| acc_dram_addr | output | 32 | DRAM address for a DRAM-routed access |
| tseg_size | output | 32 | Segment size in bytes |
| tseg_base | output | 32 | Segment base address |

## Verification
The bench sweeps every combination of open, global enable, high enable and SMM flag. For each one it probes both edges of the low and high windows and the bytes just outside them. A design that swapped the high-enable sense would expose the low window while claiming the high one. A design that missed the SMM global-enable term would deny system-management code its memory. Each segment size code is combined with two memory tops and probed at base minus one, base, top minus one and top. An off-by-one there would blackhole ordinary DRAM, or would leak the segment to non-SMM code. The lock sequence writes lock and open together, then tries to reopen and resize. A design that applied the lock a cycle late, or kept the full write mask, would leave the window open.

// File: rtl/smr_pkg.sv
`timescale 1ns/1ps
package smr_pkg;

    localparam int ADDR_W = 32;
    localparam int CFG_W  = 16;
    localparam int REG_W  = 8;

    typedef enum logic [1:0] {
        RT_DRAM = 2'd0,
        RT_PASS = 2'd1,
        RT_HOLE = 2'd2
    } route_e;

    typedef enum logic [1:0] {
        SEL_SMR  = 2'd0,
        SEL_ESM  = 2'd1,
        SEL_EXT  = 2'd2,
        SEL_NONE = 2'd3
    } cfg_sel_e;

    // first control register bit positions
    localparam int B_OPEN = 6;
    localparam int B_CLS  = 5;
    localparam int B_LCK  = 4;
    localparam int B_GEN  = 3;
    // second control register bit positions
    localparam int B_HEN  = 7;
    localparam int B_TSZ  = 1;
    localparam int B_TEN  = 0;

    localparam logic [REG_W-1:0] SMR_RST       = 8'h02;
    localparam logic [REG_W-1:0] SMR_MASK_FULL = 8'h78;
    localparam logic [REG_W-1:0] SMR_MASK_LOCK = 8'h20;
    localparam logic [REG_W-1:0] ESM_RST       = 8'h38;
    localparam logic [REG_W-1:0] ESM_MASK_FULL = 8'h87;
    localparam logic [REG_W-1:0] ESM_MASK_LOCK = 8'h00;

    localparam logic [CFG_W-1:0] EXT_QUERY  = 16'hFFFF;
    localparam int               EXT_MB_MAX = 4095;
    localparam int               MB_SHIFT   = 20;

    localparam logic [ADDR_W-1:0] LOW_WIN_BASE  = 32'h000A_0000;
    localparam logic [ADDR_W-1:0] HIGH_WIN_BASE = 32'hFEDA_0000;
    localparam logic [ADDR_W-1:0] WIN_SIZE      = 32'h0002_0000;

    typedef struct packed {
        logic open;
        logic gen;
    } smr_view_t;

    typedef struct packed {
        logic       hen;
        logic [1:0] tsz;
        logic       ten;
    } esm_view_t;

    function automatic logic [REG_W-1:0] masked_merge(
        input logic [REG_W-1:0] cur,
        input logic [REG_W-1:0] wd,
        input logic [REG_W-1:0] mask
    );
        return (cur & ~mask) | (wd & mask);
    endfunction

    function automatic smr_view_t smr_decode(input logic [REG_W-1:0] r);
        smr_view_t v;
        v.open = r[B_OPEN];
        v.gen  = r[B_GEN];
        return v;
    endfunction

    function automatic esm_view_t esm_decode(input logic [REG_W-1:0] r);
        esm_view_t v;
        v.hen = r[B_HEN];
        v.tsz = r[B_TSZ +: 2];
        v.ten = r[B_TEN];
        return v;
    endfunction

    function automatic logic in_window(
        input logic [ADDR_W-1:0] a,
        input logic [ADDR_W-1:0] base,
        input logic [ADDR_W-1:0] size
    );
        return (a >= base) && ((a - base) < size);
    endfunction

endpackage

// File: rtl/smr_ctrl_regs.sv
`timescale 1ns/1ps
module smr_ctrl_regs
    import smr_pkg::*;
#(
    parameter int EXT_MB = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_we,
    input  logic [1:0]       cfg_sel,
    input  logic [CFG_W-1:0] cfg_wdata,
    output logic [REG_W-1:0] smr_q,
    output logic [REG_W-1:0] esm_q,
    output logic [CFG_W-1:0] ext_q
);

    localparam int EXT_MB_EFF = (EXT_MB > EXT_MB_MAX) ? EXT_MB_MAX : EXT_MB;

    logic             locked;
    logic [REG_W-1:0] smr_mask;
    logic [REG_W-1:0] esm_mask;
    logic [REG_W-1:0] smr_nxt;
    logic [REG_W-1:0] esm_nxt;

    assign locked = smr_q[B_LCK];

    always_comb begin
        smr_mask = locked ? SMR_MASK_LOCK : SMR_MASK_FULL;
        esm_mask = locked ? ESM_MASK_LOCK : ESM_MASK_FULL;
        smr_nxt  = masked_merge(smr_q, cfg_wdata[REG_W-1:0], smr_mask);
        if (smr_nxt[B_LCK]) begin
            smr_nxt[B_OPEN] = 1'b0;
        end
        esm_nxt  = masked_merge(esm_q, cfg_wdata[REG_W-1:0], esm_mask);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            smr_q <= SMR_RST;
            esm_q <= ESM_RST;
        end else if (cfg_we) begin
            case (cfg_sel)
                SEL_SMR: smr_q <= smr_nxt;
                SEL_ESM: esm_q <= esm_nxt;
                default: ;
            endcase
        end
    end

    generate
        if (EXT_MB_EFF > 0) begin : g_query
            always_ff @(posedge clk) begin
                if (rst) begin
                    ext_q <= EXT_QUERY;
                end else if (cfg_we && (cfg_sel == SEL_EXT)) begin
                    ext_q <= (cfg_wdata == EXT_QUERY) ? CFG_W'(EXT_MB_EFF) : cfg_wdata;
                end
            end
        end else begin : g_plain
            always_ff @(posedge clk) begin
                if (rst) begin
                    ext_q <= '0;
                end else if (cfg_we && (cfg_sel == SEL_EXT)) begin
                    ext_q <= cfg_wdata;
                end
            end
        end
    endgenerate

    // R3
    lock_closes_open_chk: assert property (@(posedge clk) disable iff (rst)
        smr_q[B_LCK] |-> !smr_q[B_OPEN]);

    // R3
    lock_holds_policy_chk: assert property (@(posedge clk) disable iff (rst)
        smr_q[B_LCK] |=> (smr_q[B_LCK] && $stable(esm_q)
                          && $stable(smr_q[B_OPEN]) && $stable(smr_q[B_GEN])));

    // R2
    fixed_bits_chk: assert property (@(posedge clk) disable iff (rst)
        !rst |=> ($stable(smr_q[2:0]) && $stable(smr_q[7]) && $stable(esm_q[6:3])));

endmodule

// File: rtl/smr_tseg_calc.sv
`timescale 1ns/1ps
module smr_tseg_calc
    import smr_pkg::*;
#(
    parameter int EXT_MB = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  esm_view_t         esm_v,
    input  logic [ADDR_W-1:0] low_top,
    output logic [ADDR_W-1:0] tseg_size,
    output logic [ADDR_W-1:0] tseg_base
);

    localparam int EXT_MB_EFF = (EXT_MB > EXT_MB_MAX) ? EXT_MB_MAX : EXT_MB;
    localparam logic [ADDR_W-1:0] ONE_MB    = ADDR_W'(1) << MB_SHIFT;
    localparam logic [ADDR_W-1:0] TWO_MB    = ADDR_W'(2) << MB_SHIFT;
    localparam logic [ADDR_W-1:0] EIGHT_MB  = ADDR_W'(8) << MB_SHIFT;
    localparam logic [ADDR_W-1:0] EXT_BYTES = ADDR_W'(EXT_MB_EFF) << MB_SHIFT;

    always_comb begin
        if (!esm_v.ten) begin
            tseg_size = '0;
        end else begin
            case (esm_v.tsz)
                2'd0:    tseg_size = ONE_MB;
                2'd1:    tseg_size = TWO_MB;
                2'd2:    tseg_size = EIGHT_MB;
                default: tseg_size = EXT_BYTES;
            endcase
        end
        tseg_base = (tseg_size > low_top) ? '0 : (low_top - tseg_size);
    end

    // R4
    tseg_off_chk: assert property (@(posedge clk) disable iff (rst)
        !esm_v.ten |-> (tseg_size == '0));

    // R4
    tseg_std_size_chk: assert property (@(posedge clk) disable iff (rst)
        (esm_v.ten && (esm_v.tsz != 2'd3)) |-> ($countones(tseg_size) == 1));

    // R5
    tseg_base_bound_chk: assert property (@(posedge clk) disable iff (rst)
        (tseg_size != '0) |-> (tseg_base <= low_top));

endmodule

// File: rtl/smr_route.sv
`timescale 1ns/1ps
module smr_route
    import smr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic              acc_smm,
    input  smr_view_t         smr_v,
    input  logic              hen,
    input  logic [ADDR_W-1:0] tseg_size,
    input  logic [ADDR_W-1:0] tseg_base,
    input  logic [ADDR_W-1:0] low_top,
    output route_e            route,
    output logic [ADDR_W-1:0] dram_addr
);

    logic in_tseg;
    logic in_low;
    logic in_high;
    logic low_open;
    logic low_smm;
    logic high_open;

    assign in_tseg = (tseg_size != '0) && (acc_addr >= tseg_base) && (acc_addr < low_top);
    assign in_low  = in_window(acc_addr, LOW_WIN_BASE, WIN_SIZE);
    assign in_high = in_window(acc_addr, HIGH_WIN_BASE, WIN_SIZE);

    // policy terms
    assign low_open  = smr_v.open && !hen;
    assign low_smm   = acc_smm && smr_v.gen && !hen;
    assign high_open = hen && (smr_v.open || (acc_smm && smr_v.gen));

    always_comb begin
        if (in_tseg) begin
            route = acc_smm ? RT_DRAM : RT_HOLE;
        end else if (in_high) begin
            route = high_open ? RT_DRAM : RT_PASS;
        end else if (in_low) begin
            route = (low_open || low_smm) ? RT_DRAM : RT_PASS;
        end else begin
            route = (acc_addr < low_top) ? RT_DRAM : RT_PASS;
        end
        dram_addr = in_high ? (acc_addr - HIGH_WIN_BASE + LOW_WIN_BASE) : acc_addr;
    end

    // R6
    hole_only_nonsmm_chk: assert property (@(posedge clk) disable iff (rst)
        (route == RT_HOLE) |-> !acc_smm);

    // R9
    high_needs_hen_chk: assert property (@(posedge clk) disable iff (rst)
        (in_high && !in_tseg && (route == RT_DRAM)) |-> hen);

    // R7
    low_closed_pass_chk: assert property (@(posedge clk) disable iff (rst)
        (in_low && !in_tseg && !acc_smm && !smr_v.open) |-> (route == RT_PASS));

endmodule

// File: rtl/smram_gate.sv
`timescale 1ns/1ps
module smram_gate
    import smr_pkg::*;
#(
    parameter int EXT_MB = 16
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        cfg_we,
    input  logic [1:0]  cfg_sel,
    input  logic [15:0] cfg_wdata,
    output logic [7:0]  smram_q,
    output logic [7:0]  esm_q,
    output logic [15:0] ext_q,
    input  logic [31:0] low_top,
    input  logic [31:0] acc_addr,
    input  logic        acc_smm,
    output logic [1:0]  acc_route,
    output logic [31:0] acc_dram_addr,
    output logic [31:0] tseg_size,
    output logic [31:0] tseg_base
);

    smr_view_t smr_v;
    esm_view_t esm_v;
    route_e    route_w;

    smr_ctrl_regs #(.EXT_MB(EXT_MB)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (cfg_we),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .smr_q     (smram_q),
        .esm_q     (esm_q),
        .ext_q     (ext_q)
    );

    assign smr_v = smr_decode(smram_q);
    assign esm_v = esm_decode(esm_q);

    smr_tseg_calc #(.EXT_MB(EXT_MB)) u_tseg (
        .clk       (clk),
        .rst       (rst),
        .esm_v     (esm_v),
        .low_top   (low_top),
        .tseg_size (tseg_size),
        .tseg_base (tseg_base)
    );

    smr_route u_route (
        .clk       (clk),
        .rst       (rst),
        .acc_addr  (acc_addr),
        .acc_smm   (acc_smm),
        .smr_v     (smr_v),
        .hen       (esm_v.hen),
        .tseg_size (tseg_size),
        .tseg_base (tseg_base),
        .low_top   (low_top),
        .route     (route_w),
        .dram_addr (acc_dram_addr)
    );

    assign acc_route = route_w;

endmodule

// File: tb/sim_smram_gate.sv
`timescale 1ns/1ps
module sim_smram_gate;

    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_we;
    logic [1:0]  cfg_sel;
    logic [15:0] cfg_wdata;
    logic [7:0]  smram_q;
    logic [7:0]  esm_q;
    logic [15:0] ext_q;
    logic [31:0] low_top;
    logic [31:0] acc_addr;
    logic        acc_smm;
    logic [1:0]  acc_route;
    logic [31:0] acc_dram_addr;
    logic [31:0] tseg_size;
    logic [31:0] tseg_base;

    int   n_chk = 0;
    int   n_bad = 0;
    logic done  = 1'b0;

    logic [7:0]  m_smr;
    logic [7:0]  m_esm;
    logic [15:0] m_ext;

    always #2.5 clk = ~clk;

    smram_gate u0 (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .smram_q(smram_q), .esm_q(esm_q), .ext_q(ext_q), .low_top(low_top),
        .acc_addr(acc_addr), .acc_smm(acc_smm), .acc_route(acc_route),
        .acc_dram_addr(acc_dram_addr), .tseg_size(tseg_size), .tseg_base(tseg_base)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] model_size(input logic [7:0] e);
        if (!e[0]) return 32'd0;
        case (e[2:1])
            2'd0:    return 32'h0010_0000;
            2'd1:    return 32'h0020_0000;
            2'd2:    return 32'h0080_0000;
            default: return 32'h0100_0000;
        endcase
    endfunction

    function automatic logic [31:0] model_base(input logic [31:0] sz, input logic [31:0] top);
        return (sz > top) ? 32'd0 : top - sz;
    endfunction

    function automatic logic [1:0] model_route(input logic [31:0] a, input logic s);
        logic [31:0] sz;
        logic [31:0] bs;
        logic o, g, h;
        sz = model_size(m_esm);
        bs = model_base(sz, low_top);
        o = m_smr[6];
        g = m_smr[3];
        h = m_esm[7];
        if (sz != 0 && a >= bs && a < low_top) return s ? 2'd0 : 2'd2;
        if (a >= 32'hFEDA0000 && a < 32'hFEDC0000) return ((o && h) || (s && g && h)) ? 2'd0 : 2'd1;
        if (a >= 32'h000A0000 && a < 32'h000C0000) return ((o && !h) || (s && g && !h)) ? 2'd0 : 2'd1;
        return (a < low_top) ? 2'd0 : 2'd1;
    endfunction

    task automatic wr(input logic [1:0] sel, input logic [15:0] d);
        logic [7:0] mk;
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_sel = sel;
        cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
        if (sel == 2'd0) begin
            mk = m_smr[4] ? 8'h20 : 8'h78;
            m_smr = (m_smr & ~mk) | (d[7:0] & mk);
            if (m_smr[4]) m_smr[6] = 1'b0;
        end else if (sel == 2'd1) begin
            mk = m_smr[4] ? 8'h00 : 8'h87;
            m_esm = (m_esm & ~mk) | (d[7:0] & mk);
        end else if (sel == 2'd2) begin
            m_ext = (d == 16'hFFFF) ? 16'd16 : d;
        end
    endtask

    task automatic check_regs(input string req);
        #1;
        chk(req, {24'd0, smram_q}, {24'd0, m_smr});
        chk(req, {24'd0, esm_q}, {24'd0, m_esm});
        chk(req, {16'd0, ext_q}, {16'd0, m_ext});
    endtask

    task automatic probe(input string req, input logic [31:0] a, input logic s);
        logic [1:0]  er;
        logic [31:0] ea;
        acc_addr = a;
        acc_smm = s;
        #1;
        er = model_route(a, s);
        chk(req, {30'd0, acc_route}, {30'd0, er});
        if (er == 2'd0) begin
            ea = (a >= 32'hFEDA0000 && a < 32'hFEDC0000) ? (a - 32'hFEDA0000 + 32'h000A0000) : a;
            chk(req, acc_dram_addr, ea);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        cfg_we = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        m_smr = 8'h02;
        m_esm = 8'h38;
        m_ext = 16'hFFFF;
    endtask

    initial begin
        logic [31:0] addrs [9];
        logic [31:0] tops [2];
        addrs = '{32'h000A0000, 32'h000BFFFF, 32'h000C0000, 32'h0009FFFF,
                  32'hFEDA0000, 32'hFEDBFFFF, 32'hFEDC0000, 32'h7EFFFFFF, 32'h7F000000};
        tops = '{32'h80000000, 32'h7F000000};
        cfg_sel = 2'd3;
        cfg_wdata = 16'd0;
        low_top = 32'h7F000000;
        acc_addr = 32'd0;
        acc_smm = 1'b0;
        do_reset();

        // R1 reset values, R5 no segment after reset
        check_regs("R1");
        chk("R5", tseg_size, 32'd0);

        // R2 write masks
        wr(2'd0, 16'h00EF); check_regs("R2");
        chk("R2", {24'd0, smram_q}, 32'h6A);
        wr(2'd0, 16'h0000); check_regs("R2");
        wr(2'd1, 16'h00FF); check_regs("R2");
        chk("R2", {24'd0, esm_q}, 32'hBF);
        wr(2'd1, 16'h0000); check_regs("R2");

        // R7 R8 R9 R10 routing sweep
        for (int cfg = 0; cfg < 8; cfg++) begin
            wr(2'd0, {8'd0, 1'b0, cfg[0], 2'b00, cfg[1], 3'b000});
            wr(2'd1, {8'd0, cfg[2], 7'd0});
            for (int s = 0; s < 2; s++) begin
                for (int k = 0; k < 9; k++) begin
                    probe("R7 R8 R9 R10", addrs[k], s[0]);
                end
            end
        end

        // R4 R5 R6 segment sweep
        wr(2'd0, 16'h0000);
        for (int t = 0; t < 2; t++) begin
            low_top = tops[t];
            for (int code = 0; code < 8; code++) begin
                logic [31:0] sz;
                logic [31:0] bs;
                wr(2'd1, {13'd0, code[2:0]});
                sz = model_size(m_esm);
                bs = model_base(sz, low_top);
                #1;
                chk("R4", tseg_size, sz);
                chk("R5", tseg_base, bs);
                for (int s = 0; s < 2; s++) begin
                    probe("R6", bs - 32'd1, s[0]);
                    probe("R6", bs, s[0]);
                    probe("R6", low_top - 32'd1, s[0]);
                    probe("R6", low_top, s[0]);
                end
            end
        end
        // R5 clamp when segment exceeds memory top
        low_top = 32'h00080000;
        wr(2'd1, 16'h0001);
        #1;
        chk("R5", tseg_base, 32'd0);
        low_top = 32'h7F000000;
        wr(2'd1, 16'h0000);

        // R11 size query
        wr(2'd2, 16'h1234); check_regs("R11");
        wr(2'd2, 16'hFFFF); check_regs("R11");
        chk("R11", {16'd0, ext_q}, 32'd16);
        wr(2'd2, 16'h0000); check_regs("R11");

        // R3 lock
        wr(2'd0, 16'h0058); check_regs("R3");
        chk("R3", {24'd0, smram_q}, 32'h1A);
        wr(2'd0, 16'h007F); check_regs("R3");
        chk("R3", {24'd0, smram_q}, 32'h3A);
        wr(2'd0, 16'h0000); check_regs("R3");
        wr(2'd1, 16'h00FF); check_regs("R3");
        probe("R3", 32'h000A0000, 1'b0);
        probe("R3", 32'h000A0000, 1'b1);
        do_reset();
        check_regs("R3");

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

endmodule